// File: doc/BRIEF.md
# Parallel Port Enhanced Write Cycle Controller

This block runs the host side of an enhanced-mode parallel port write. A host register interface hands it one byte plus a select bit that chooses an address cycle or a data cycle. The controller pulls the write-direction line low and drives the byte. One clock later it pulls the matching strobe low. It then waits for the peripheral to acknowledge by raising its wait line. After the strobe is released, the write-direction line is released on the following clock.

A watchdog counter bounds each cycle. The counter restarts when a request is accepted. If no acknowledgement arrives within the limit, the controller ends the cycle anyway and sets a sticky timeout flag in bit 0 of a status byte. No interrupt is raised. Host software polls the flag after each cycle, decides whether to retry, and clears the flag by writing a 1 to bit 0. The default limit is 10 µs, expressed in clocks and computed from the clock frequency parameter.

Top module: `epp_host_ctrl`

## Requirements
- R1: After reset, `pp_write_no`, `pp_astrb_no` and `pp_dstrb_no` are high, `pp_data_oe_o` is 0, `busy_o` is 0 and `status_o` is 8'h00.
- R2: A request accepted on a clock edge makes `pp_write_no` low, `pp_data_oe_o` high, `pp_data_o` equal to the request byte and `busy_o` high after that edge. Both strobes stay high in that first cycle.
- R3: On the next edge, the address strobe goes low if `req_addr_i` was 1, and the data strobe goes low if it was 0. The two strobes are never low together.
- R4: The wait input passes through a two-flop synchronizer and is edge detected. If it rises while a strobe is low, the strobe and `busy_o` go high on the third rising clock edge after the rise, and the timeout flag is not set.
- R5: If no rise is seen, the strobe is released and status bit 0 is set on the edge that comes exactly TIMEOUT_CYC edges after the accepting edge.
- R6: One edge after the strobe is released, `pp_write_no` returns high and `pp_data_oe_o` returns low, unless a new request is accepted on that edge.
- R7: A request that arrives while `busy_o` is high is ignored. The driven byte does not change, and no further cycle follows.
- R8: Status bit 0 is sticky. A status write with bit 0 = 0 leaves it set. A status write with bit 0 = 1 clears it on the next edge. If a timeout and a clear fall on the same edge, the timeout wins.
- R9: A new cycle may start while the flag is set. An acknowledged cycle leaves the flag set.
- R10: A request that arrives in the cycle after strobe release is accepted. `pp_write_no` stays low and a new cycle begins with the new byte and strobe.
- R11: Status bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, sampled each edge |
| req_addr_i | input | 1 | 1 = address cycle, 0 = data cycle |
| req_data_i | input | 8 | Byte to write |
| busy_o | output | 1 | High from acceptance until strobe release |
| status_wr_i | input | 1 | Status write enable |
| status_wdata_i | input | 8 | Status write data; bit 0 = 1 clears the timeout flag |
| status_o | output | 8 | Status; bit 0 is the timeout flag |
| pp_data_o | output | 8 | Port data lines |
| pp_data_oe_o | output | 1 | Data output enable |
| pp_write_no | output | 1 | Write-direction line, active low |
| pp_astrb_no | output | 1 | Address strobe, active low |
| pp_dstrb_no | output | 1 | Data strobe, active low |
| pp_wait_i | input | 1 | Peripheral wait/acknowledge line, asynchronous |

## Verification
A wrong state in the sequencer shows at the port pins within one clock. Examples are a strobe without the write-direction line, both strobes low, or the write-direction line left low after release. A fault in the synchronizer or the edge detector moves the strobe release away from the third edge after the acknowledgement, or turns an acknowledged cycle into a timeout. A fault in the watchdog shows up as a release that is off by even one clock from TIMEOUT_CYC edges after acceptance. Flag faults are visible on `status_o` one edge after a set or clear, and when a set and a clear collide on the same edge.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } epp_state_e;
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned CW   = $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_host_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic addr_sel_i,
  input  logic ack_rise_i,
  input  logic expire_i,
  output logic accept_o,
  output logic timeout_o,
  output logic wdog_run_o,
  output logic busy_o,
  output logic write_no,
  output logic astrb_no,
  output logic dstrb_no
);
  epp_state_e state_q, state_d;
  logic sel_q;
  logic write_nq, astrb_nq, dstrb_nq;

  assign accept_o = req_i && (state_q == ST_IDLE || state_q == ST_HOLD);

  always_comb begin
    state_d   = state_q;
    timeout_o = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: begin
        if (ack_rise_i) state_d = ST_HOLD;
        else if (expire_i) begin
          state_d   = ST_HOLD;
          timeout_o = 1'b1;
        end
      end
      ST_HOLD:   state_d = accept_o ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= 1'b0;
      write_nq <= 1'b1;
      astrb_nq <= 1'b1;
      dstrb_nq <= 1'b1;
    end else begin
      state_q  <= state_d;
      if (accept_o) sel_q <= addr_sel_i;
      write_nq <= (state_d == ST_IDLE);
      astrb_nq <= !(state_d == ST_STROBE && sel_q);
      dstrb_nq <= !(state_d == ST_STROBE && !sel_q);
    end
  end

  assign wdog_run_o = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign busy_o     = wdog_run_o;
  assign write_no   = write_nq;
  assign astrb_no   = astrb_nq;
  assign dstrb_no   = dstrb_nq;
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl #(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned TIMEOUT_NS  = 10000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 8,
  localparam int unsigned TIMEOUT_CYC = CLK_MHZ * TIMEOUT_NS / 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          busy_o,
  input  logic          status_wr_i,
  input  logic [7:0]    status_wdata_i,
  output logic [7:0]    status_o,
  output logic [DW-1:0] pp_data_o,
  output logic          pp_data_oe_o,
  output logic          pp_write_no,
  output logic          pp_astrb_no,
  output logic          pp_dstrb_no,
  input  logic          pp_wait_i
);
  logic accept, timeout_evt, wdog_run, expire, ack_rise, ack_lvl;
  logic [DW-1:0] data_q;
  logic to_flag_q;

  epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pp_wait_i),
    .level_o(ack_lvl), .rise_o(ack_rise)
  );

  epp_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept),
    .run_i(wdog_run), .expire_o(expire)
  );

  epp_cycle_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_sel_i(req_addr_i),
    .ack_rise_i(ack_rise), .expire_i(expire), .accept_o(accept),
    .timeout_o(timeout_evt), .wdog_run_o(wdog_run), .busy_o(busy_o),
    .write_no(pp_write_no), .astrb_no(pp_astrb_no), .dstrb_no(pp_dstrb_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (accept) data_q <= req_data_i;
  end

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  to_flag_q <= 1'b0;
    else if (timeout_evt)                         to_flag_q <= 1'b1;
    else if (status_wr_i && status_wdata_i[0])    to_flag_q <= 1'b0;
  end

  logic unused_lvl;
  assign unused_lvl   = ack_lvl;
  assign status_o     = {7'b0, to_flag_q};
  assign pp_data_o    = data_q;
  assign pp_data_oe_o = ~pp_write_no;
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned DW          = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          status_wr_i,
  input logic [7:0]    status_wdata_i,
  input logic [7:0]    status_o,
  input logic [DW-1:0] pp_data_o,
  input logic          pp_write_no,
  input logic          pp_astrb_no,
  input logic          pp_dstrb_no
);
  logic strb_low;
  logic [31:0] low_cnt_q;
  assign strb_low = !pp_astrb_no || !pp_dstrb_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt_q <= '0;
    else if (strb_low) low_cnt_q <= low_cnt_q + 1;
    else               low_cnt_q <= '0;
  end

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!pp_astrb_no && !pp_dstrb_no));

  a_r2_strobe_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |-> !pp_write_no);

  a_r4_busy_covers_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |-> busy_o);

  a_r7_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pp_data_o));

  a_r5_watchdog_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt_q < TIMEOUT_CYC);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !(status_wr_i && status_wdata_i[0])) |=> status_o[0]);

  a_r11_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:1] == 7'b0);
endmodule

bind epp_host_ctrl epp_host_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o),
  .status_wr_i(status_wr_i), .status_wdata_i(status_wdata_i), .status_o(status_o),
  .pp_data_o(pp_data_o), .pp_write_no(pp_write_no),
  .pp_astrb_no(pp_astrb_no), .pp_dstrb_no(pp_dstrb_no)
);

// File: tb/epp_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module epp_host_ctrl_tb_top;
  localparam int TO = 1000;

  typedef struct packed {
    logic       is_addr;
    logic [7:0] data;
    logic [7:0] ack_dly;  // 0 = peripheral never acknowledges
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 8'hA5, 8'd1},
    '{1'b0, 8'h5A, 8'd4},
    '{1'b1, 8'h00, 8'd0},
    '{1'b0, 8'hFF, 8'd9},
    '{1'b0, 8'h81, 8'd0},
    '{1'b1, 8'h7E, 8'd20}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_addr = 1'b0, st_wr = 1'b0, wait_i = 1'b0;
  logic [7:0] req_data = '0, st_wdata = '0, status, pd;
  logic busy, poe, wr_n, as_n, ds_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  epp_host_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_data_i(req_data), .busy_o(busy), .status_wr_i(st_wr),
    .status_wdata_i(st_wdata), .status_o(status), .pp_data_o(pd),
    .pp_data_oe_o(poe), .pp_write_no(wr_n), .pp_astrb_no(as_n),
    .pp_dstrb_no(ds_n), .pp_wait_i(wait_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; req_addr = a; req_data = d;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic stat_write(input logic [7:0] w);
    @(negedge clk); st_wr = 1'b1; st_wdata = w;
    @(negedge clk); st_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk(wr_n && as_n && ds_n && !poe && !busy, "R1 pins", {wr_n, as_n, ds_n, poe, busy}, 5'b11100);
    chk(status == 8'h00, "R1 status", status, 8'h00);
    rst_n = 1'b1;
    step(2);

    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      start(v.is_addr, v.data);
      chk(busy && !wr_n && poe && pd == v.data, "R2 setup", {busy, wr_n, poe, pd}, {3'b101, v.data});
      chk(as_n && ds_n, "R2 strobes idle", {as_n, ds_n}, 2'b11);
      step(1);
      chk(as_n == !v.is_addr && ds_n == v.is_addr, "R3 strobe select", {as_n, ds_n}, {!v.is_addr, v.is_addr});
      if (v.ack_dly != 0) begin
        step(int'(v.ack_dly) - 1);
        wait_i = 1'b1;
        step(2);
        chk(!(as_n && ds_n) && busy, "R4 strobe held during sync", {as_n, ds_n, busy}, 3'b001);
        step(1);
        chk(as_n && ds_n && !busy && !wr_n, "R4 release on third edge", {as_n, ds_n, busy, wr_n}, 4'b1100);
        step(1);
        chk(wr_n && !poe, "R6 write released", {wr_n, poe}, 2'b10);
        chk(status[0] == 1'b0, "R4 no timeout", status, 8'h00);
      end else begin
        step(TO - 2);
        chk(!(as_n && ds_n) && busy && status[0] == 1'b0, "R5 still waiting", {as_n, ds_n, busy, status[0]}, 4'b0010);
        step(1);
        chk(as_n && ds_n && status[0], "R5 timeout release", {as_n, ds_n, status[0]}, 3'b111);
        step(1);
        chk(wr_n && !poe, "R6 write released", {wr_n, poe}, 2'b10);
      end
      chk(status[7:1] == 7'b0, "R11 upper bits", status, {7'b0, status[0]});
      wait_i = 1'b0;
      step(3);
      stat_write(8'h01);
      chk(status == 8'h00, "R8 clear", status, 8'h00);
    end

    // R7: request while busy is ignored
    start(1'b0, 8'h3C);
    step(1);
    req = 1'b1; req_data = 8'hFF; req_addr = 1'b1;
    step(1);
    req = 1'b0;
    chk(pd == 8'h3C && !ds_n, "R7 data kept", pd, 8'h3C);
    wait_i = 1'b1;
    step(3);
    chk(ds_n && as_n, "R7 strobe released", {as_n, ds_n}, 2'b11);
    step(1);
    chk(wr_n, "R7 no extra cycle", wr_n, 1'b1);
    step(1);
    chk(wr_n && !busy, "R7 stays idle", {wr_n, busy}, 2'b10);
    wait_i = 1'b0;
    step(3);

    // R8: timeout and clear on the same edge, set wins
    start(1'b1, 8'h11);
    step(1);
    step(TO - 2);
    st_wr = 1'b1; st_wdata = 8'h01;
    step(1);
    st_wr = 1'b0;
    chk(status[0] == 1'b1 && as_n, "R8 set wins", status, 8'h01);
    stat_write(8'hFE);
    chk(status[0] == 1'b1, "R8 bit0=0 write keeps flag", status, 8'h01);

    // R9: cycle with flag set, acknowledged, flag stays
    start(1'b0, 8'h22);
    chk(busy && !wr_n, "R9 accepted with flag set", {busy, wr_n}, 2'b10);
    step(1);
    wait_i = 1'b1;
    step(3);
    chk(ds_n && status[0] == 1'b1, "R9 flag sticky over ack", {ds_n, status[0]}, 2'b11);
    step(1);
    wait_i = 1'b0;
    step(3);
    stat_write(8'h01);
    chk(status == 8'h00, "R8 cleared", status, 8'h00);

    // R10: request in the cycle right after strobe release
    start(1'b1, 8'h44);
    step(1);
    wait_i = 1'b1;
    step(3);
    chk(as_n && !wr_n && !busy, "R10 hold cycle", {as_n, wr_n, busy}, 3'b100);
    req = 1'b1; req_addr = 1'b0; req_data = 8'h55;
    wait_i = 1'b0;
    step(1);
    req = 1'b0;
    chk(!wr_n && busy && pd == 8'h55, "R10 back-to-back accept", {wr_n, busy, pd}, {2'b01, 8'h55});
    step(1);
    chk(!ds_n && as_n, "R10 new strobe", {as_n, ds_n}, 2'b10);
    step(2);
    wait_i = 1'b1;
    step(3);
    chk(ds_n && !busy && status[0] == 1'b0, "R10 second ack", {ds_n, busy, status[0]}, 3'b100);
    step(1);
    chk(wr_n, "R6 write released after back-to-back", wr_n, 1'b1);
    wait_i = 1'b0;
    step(3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule